// File: doc/BRIEF.md
# Transmit Clock Loss Alarm

This block watches the clocks that time a line transmitter. It samples each one as data in a free-running reference clock domain. When any qualified clock stops toggling for a few microseconds, it raises a live alarm. It turns the line driver enable off while that alarm is live. It also keeps a sticky status bit that is cleared when software reads it. It can raise a one-cycle interrupt pulse when the alarm goes high.

Four sources are monitored:

| Source | When it is monitored |
|---|---|
| Transmit input clock | Always |
| Internal pulse-shaper clock | Always |
| Receive clock | Only while remote loopback is on |
| Jitter-attenuator output clock | Only while that path is selected |

Switching loopback on or off moves the transmit timing to a different clock, and that switch can produce a false alarm. An optional mask blanks the alarm and restarts all loss timers for a short window after each loopback change. During steady loopback, monitoring behaves normally.

Top module: `tx_clk_loss_alarm`

## Requirements
- R1: `alarm_o` is the OR of the loss flags of the qualified sources. The transmit and pulse-shaper clocks are always qualified. The receive clock is qualified only while `rloop_i`=1. The jitter-attenuator clock is qualified only while `jat_en_i`=1. A stopped source that is not qualified never raises `alarm_o`.
- R2: Once a qualified clock stops, `alarm_o` rises no sooner than 3 µs and no later than 16 µs later. At the default 200 MHz reference, this is 600 to 3200 reference cycles.
- R3: When a lost clock toggles again, `alarm_o` falls within a few reference cycles of the first edge. The delay is set only by the synchroniser, with no timeout.
- R4: `line_oe_o` is 0 exactly while `alarm_o` is 1, and 1 otherwise.
- R5: `status_o` goes to 1 in the cycle after `alarm_o` rises. It stays 1 until a cycle with `stat_rd_i`=1, which clears it on the next edge. A falling alarm never sets it.
- R6: With `irq_en_i`=1, `irq_o` is a one-cycle pulse in the cycle after `alarm_o` rises. With `irq_en_i`=0, `irq_o` stays 0.
- R7: With `mask_en_i`=1, each change of `rloop_i` holds `alarm_o` at 0 for the next 32 reference cycles and restarts every loss timer. After the window, a clock that is still missing alarms again after the normal timeout. With `mask_en_i`=0, a change of `rloop_i` has no effect on a live alarm.
- R8: If `stat_rd_i`=1 in the same cycle that `alarm_o` rises, `status_o` is 1 after that edge.
- R9: While `rst_ni` is low, `alarm_o`, `status_o` and `irq_o` are 0 and `line_oe_o` is 1. Every loss timer starts full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_clk_i | input | 1 | Monitored transmit input clock |
| rx_clk_i | input | 1 | Monitored receive clock (qualified in loopback) |
| jat_clk_i | input | 1 | Monitored jitter-attenuator output clock |
| pwc_clk_i | input | 1 | Monitored internal pulse-shaper clock |
| rloop_i | input | 1 | Remote loopback active |
| jat_en_i | input | 1 | Jitter attenuator in transmit path |
| mask_en_i | input | 1 | Enable loopback-transient alarm mask |
| irq_en_i | input | 1 | Interrupt enable |
| stat_rd_i | input | 1 | Status read strobe, clears status |
| alarm_o | output | 1 | Live loss-of-clock alarm |
| status_o | output | 1 | Latched alarm status, clear on read |
| irq_o | output | 1 | Interrupt pulse on rising alarm |
| line_oe_o | output | 1 | Line driver enable, 0 forces high impedance |

## Verification
A status read can land in the same cycle as a new alarm rising edge, so a read must not drop the event that it races. The bench provokes this by holding the read strobe high during the whole timeout, so the alarm rises while a read is in progress. It then expects `status_o` to be 1 right after the rising edge. It expects `status_o` to be 0 one cycle later, once only the read remains.

// File: rtl/tx_loss_pkg.sv
package tx_loss_pkg;
  typedef enum int unsigned {
    SRC_TX  = 0,
    SRC_RX  = 1,
    SRC_JAT = 2,
    SRC_PWC = 3
  } src_e;
  localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/clk_edge_mon.sv
module clk_edge_mon #(
  parameter int unsigned TIMEOUT = 1900,
  parameter int unsigned MIN_CYC = 600,
  parameter int unsigned MAX_CYC = 3200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_clk_i,
  input  logic en_i,
  output logic lost_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam int unsigned QW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT);
  localparam logic [QW-1:0] QMIN = QW'(MIN_CYC);
  localparam logic [QW-1:0] QMAX = QW'(MAX_CYC);

  logic [2:0]    sync_q;
  logic          edge_w;
  logic [CW-1:0] cnt_q;

  assign edge_w = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= RELOAD;
    end else begin
      sync_q <= {sync_q[1:0], mon_clk_i};
      if (!en_i || edge_w)  cnt_q <= RELOAD;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign lost_o = (cnt_q == '0);

  // quiet-time counter used only for checking the timing window
  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                quiet_q <= '0;
    else if (!en_i || edge_w)   quiet_q <= '0;
    else if (quiet_q < QMAX)    quiet_q <= quiet_q + 1'b1;
  end

  a_r2_not_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> (quiet_q >= QMIN));
  a_r2_not_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && quiet_q >= QMAX) |-> lost_o);
  a_r3_edge_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && edge_w) |=> !lost_o);
endmodule

// File: rtl/rloop_mask.sv
module rloop_mask #(
  parameter int unsigned MASK_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rloop_i,
  input  logic mask_en_i,
  output logic hold_o
);
  localparam int unsigned MW = $clog2(MASK_CYC + 1);
  localparam logic [MW-1:0] MLOAD = MW'(MASK_CYC);

  logic          rloop_q;
  logic          chg_w;
  logic [MW-1:0] win_q;

  assign chg_w = rloop_i ^ rloop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rloop_q <= 1'b0;
      win_q   <= '0;
    end else begin
      rloop_q <= rloop_i;
      if (chg_w)            win_q <= MLOAD;
      else if (win_q != '0) win_q <= win_q - 1'b1;
    end
  end

  assign hold_o = mask_en_i && (win_q != '0);

  a_r7_mask_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_en_i && chg_w) |=> (!mask_en_i || hold_o));
endmodule

// File: rtl/alarm_status.sv
module alarm_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alarm_i,
  input  logic irq_en_i,
  input  logic rd_i,
  output logic status_o,
  output logic irq_o
);
  logic alarm_q, status_q, irq_q, rise_w;

  assign rise_w = alarm_i & ~alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q  <= 1'b0;
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      alarm_q  <= alarm_i;
      // a new event wins over a concurrent read
      status_q <= (status_q & ~rd_i) | rise_w;
      irq_q    <= rise_w & irq_en_i;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  a_r5_set_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_w |=> status_o);
  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rise_w) |=> !status_o);
  a_r8_read_race: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rise_w) |=> status_o);
  a_r6_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !irq_o);
  a_r6_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/tx_clk_loss_alarm.sv
module tx_clk_loss_alarm
  import tx_loss_pkg::*;
#(
  parameter int unsigned REF_MHZ  = 200,
  parameter int unsigned MIN_US   = 3,
  parameter int unsigned MAX_US   = 16,
  parameter int unsigned MASK_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_clk_i,
  input  logic rx_clk_i,
  input  logic jat_clk_i,
  input  logic pwc_clk_i,
  input  logic rloop_i,
  input  logic jat_en_i,
  input  logic mask_en_i,
  input  logic irq_en_i,
  input  logic stat_rd_i,
  output logic alarm_o,
  output logic status_o,
  output logic irq_o,
  output logic line_oe_o
);
  localparam int unsigned MIN_CYC = REF_MHZ * MIN_US;
  localparam int unsigned MAX_CYC = REF_MHZ * MAX_US;
  localparam int unsigned TIMEOUT = (MIN_CYC + MAX_CYC) / 2;

  logic [NUM_SRC-1:0] mon_clk, qual, lost;
  logic               hold;

  always_comb begin
    mon_clk          = '0;
    qual             = '0;
    mon_clk[SRC_TX]  = tx_clk_i;
    mon_clk[SRC_RX]  = rx_clk_i;
    mon_clk[SRC_JAT] = jat_clk_i;
    mon_clk[SRC_PWC] = pwc_clk_i;
    qual[SRC_TX]     = 1'b1;
    qual[SRC_RX]     = rloop_i;
    qual[SRC_JAT]    = jat_en_i;
    qual[SRC_PWC]    = 1'b1;
  end

  rloop_mask #(.MASK_CYC(MASK_CYC)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rloop_i   (rloop_i),
    .mask_en_i (mask_en_i),
    .hold_o    (hold)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mon
    clk_edge_mon #(
      .TIMEOUT (TIMEOUT),
      .MIN_CYC (MIN_CYC),
      .MAX_CYC (MAX_CYC)
    ) u_mon (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mon_clk_i (mon_clk[i]),
      .en_i      (qual[i] & ~hold),
      .lost_o    (lost[i])
    );
  end

  assign alarm_o   = (|(lost & qual)) & ~hold;
  assign line_oe_o = ~alarm_o;

  alarm_status u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alarm_i  (alarm_o),
    .irq_en_i (irq_en_i),
    .rd_i     (stat_rd_i),
    .status_o (status_o),
    .irq_o    (irq_o)
  );

  a_r1_unqualified_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lost[SRC_TX] && !lost[SRC_PWC] && !(rloop_i && lost[SRC_RX])
     && !(jat_en_i && lost[SRC_JAT])) |-> !alarm_o);
endmodule

// File: tb/sim_tx_clk_loss_alarm.sv
`timescale 1ns/1ps
module sim_tx_clk_loss_alarm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_clk = 0, rx_clk = 0, jat_clk = 0, pwc_clk = 0;
  logic [3:0] run = 4'b1111;
  logic rloop = 0, jat_en = 0, mask_en = 0, irq_en = 0, stat_rd = 0;
  logic alarm, status, irq, line_oe;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  localparam int LO_CYC = 600;
  localparam int HI_CYC = 3200;

  always #2.5 clk = ~clk;
  always begin #20 if (run[0]) tx_clk  = ~tx_clk;  end
  always begin #25 if (run[1]) rx_clk  = ~rx_clk;  end
  always begin #30 if (run[2]) jat_clk = ~jat_clk; end
  always begin #15 if (run[3]) pwc_clk = ~pwc_clk; end

  tx_clk_loss_alarm u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_clk_i(tx_clk), .rx_clk_i(rx_clk), .jat_clk_i(jat_clk), .pwc_clk_i(pwc_clk),
    .rloop_i(rloop), .jat_en_i(jat_en), .mask_en_i(mask_en),
    .irq_en_i(irq_en), .stat_rd_i(stat_rd),
    .alarm_o(alarm), .status_o(status), .irq_o(irq), .line_oe_o(line_oe)
  );

  function automatic bit in_window(int n);
    return (n >= LO_CYC) && (n <= HI_CYC);
  endfunction

  function automatic bit exp_oe(bit a);
    return !a;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int k = 1);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic wait_alarm(output int n);
    n = 0;
    while (!alarm && n < 4000) begin tick(); n++; end
  endtask

  task automatic loss_event(int src, bit ien, bit rd_at_rise);
    int n, m;
    irq_en = ien;
    if (src == 1) begin rloop = 1; tick(50); end
    if (src == 2) begin jat_en = 1; tick(50); end
    stat_rd = rd_at_rise;
    run[src] = 1'b0;
    wait_alarm(n);
    check(in_window(n), "R2 assert delay", n, LO_CYC);
    check(line_oe == exp_oe(1'b1), "R4 oe off", int'(line_oe), 0);
    tick();
    if (rd_at_rise) begin
      check(status == 1'b1, "R8 read race keeps status", int'(status), 1);
      tick();
      check(status == 1'b0, "R5 read clears", int'(status), 0);
      stat_rd = 0;
    end else begin
      check(status == 1'b1, "R5 status set", int'(status), 1);
      check(irq == ien, "R6 irq on rise", int'(irq), int'(ien));
      tick();
      check(irq == 1'b0, "R6 irq one cycle", int'(irq), 0);
      check(status == 1'b1, "R5 status held", int'(status), 1);
      stat_rd = 1; tick(); stat_rd = 0;
      check(status == 1'b0, "R5 read clears", int'(status), 0);
    end
    run[src] = 1'b1;
    m = 0;
    while (alarm && m < 40) begin tick(); m++; end
    check(m <= 10, "R3 fast clear", m, 10);
    check(line_oe == exp_oe(alarm), "R4 oe back", int'(line_oe), 1);
    tick(2);
    check(status == 1'b0, "R5 fall does not set", int'(status), 0);
    if (src == 1) rloop = 0;
    if (src == 2) jat_en = 0;
    tick(60);
  endtask

  initial begin
    int n;
    bit bad;
    void'($urandom(32'h5EED_0017));
    tick(3);
    // R9 reset state
    check(alarm == 1'b0, "R9 alarm", int'(alarm), 0);
    check(status == 1'b0, "R9 status", int'(status), 0);
    check(irq == 1'b0, "R9 irq", int'(irq), 0);
    check(line_oe == 1'b1, "R9 oe", int'(line_oe), 1);
    rst_n = 1;
    tick(200);
    check(alarm == 1'b0, "R1 all running", int'(alarm), 0);

    // R1 unqualified sources stopped
    run[1] = 0; run[2] = 0;
    bad = 0;
    for (int i = 0; i < 3600; i++) begin tick(); if (alarm) bad = 1; end
    check(!bad, "R1 unqualified ignored", int'(bad), 0);
    run[1] = 1; run[2] = 1;
    tick(20);

    // directed: every source once, then random mix
    for (int s = 0; s < 4; s++) loss_event(s, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      mask_en = 1'($urandom_range(0, 1));
      loss_event(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b0);
    end
    mask_en = 0;

    // R8 read strobe overlapping the rising edge
    loss_event(0, 1'b0, 1'b1);

    // R7 mask window on a live alarm
    run[0] = 0;
    wait_alarm(n);
    check(alarm == 1'b1, "R7 setup alarm", int'(alarm), 1);
    mask_en = 1;
    rloop = 1;
    tick();
    bad = 0;
    for (int i = 0; i < 31; i++) begin
      if (alarm) bad = 1;
      tick();
    end
    check(!bad, "R7 alarm blanked in window", int'(bad), 0);
    check(alarm == 1'b0, "R7 timer restarted", int'(alarm), 0);
    wait_alarm(n);
    check(in_window(n + 31), "R7 alarm returns after timeout", n + 31, LO_CYC);
    mask_en = 0;
    rloop = 0;
    bad = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (!alarm) bad = 1; end
    check(!bad, "R7 no mask when disabled", int'(bad), 0);
    run[0] = 1;
    tick(40);
    check(alarm == 1'b0, "R3 recovered", int'(alarm), 0);
    finish_run();
  end
endmodule